// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block is a byte-wide static memory whose eight highest addresses hold a running calendar clock instead of plain storage. Seconds, minutes, hours, weekday, day of month, month and two-digit year are kept as BCD bytes. A slow clock-enable input, nominally 32,768 pulses per second, is divided down to one step of the calendar per second. The host reaches the clock the same way it reaches memory, through a select pair, a write strobe, an output-enable strobe, an address and a data bus. The data bus is split into an input bus, an output bus and a flag that says when the output is driven.

A control byte carries four flags. Hold freezes the counters so new time values can be staged and then loaded together. Snapshot freezes a copy of the time for coherent multi-byte reads while counting continues. Stop halts the divider. Frequency test puts a square wave on a pin. A five-bit calibration field is stored for software and read back; it does not act on the timebase.

The storage depth is a parameter. The full-size configuration uses 13 address bits for 8192 bytes. The default uses 11 bits, so that elaboration stays small.

Top module: `rtc_sram_top`

## Requirements
- R1: After reset, rdata_oe is 0, the control byte reads 00h, the time bytes read 00 seconds, 00 minutes, 00 hours, weekday 1, date 01, month 01 and year 00, and the calibration field is 0.
- R2: A write occurs on each clock edge where cs_a_n=0, cs_b=1 and wr_en_n=0, whatever out_en_n is. Below the clock window, the byte is then stored and a later read of that address returns it. With either select inactive, nothing is stored.
- R3: rdata_oe is 1 in the cycle after an edge where cs_a_n=0, cs_b=1, wr_en_n=1 and out_en_n=0, and rdata then carries the addressed byte. In every other case rdata_oe is 0 in the next cycle.
- R4: The top eight addresses map as follows by offset. Offset 0 is control: bit 7 hold, bit 6 snapshot, bit 5 stop, bit 4 frequency test, bits 3:0 read as 0. Offsets 1, 2 and 3 are seconds, minutes and hours. Offset 4 holds the weekday in bits 2:0 and calibration in bits 7:3. Offsets 5, 6 and 7 are date, month and year.
- R5: When stop and hold are clear, TICKS_PER_SEC enabled osc_tick cycles advance seconds by exactly one, and one fewer leaves it unchanged.
- R6: Each counter carries from a low digit of 9 into the high digit. Seconds and minutes wrap 59 to 00 with a carry. Hours wrap 23 to 00 and then advance the weekday and the date. The weekday runs 1 to 7 and back to 1.
- R7: The date wraps to 01 after the month's last day. That day is 30 for months 04, 06, 09 and 11, 31 for the other months except 02, and for 02 it is 29 when the year value is divisible by 4 and 28 otherwise. The month wraps 12 to 01 and then advances the year, which wraps 99 to 00.
- R8: While hold is set, the time does not advance, and writes to time bytes go to a staging copy that starts as the live time. Clearing hold loads the staged values into the counters. With hold clear, writes to time bytes do not change the time.
- R9: Setting snapshot copies the live time, and time reads return that copy while the flag is set, while the counters keep running. Clearing it returns reads to the live counters.
- R10: While stop is set, the divider is held at zero and the time does not advance. After stop clears, a full TICKS_PER_SEC enables are needed for the next step.
- R11: freq_test stays 0 while the frequency-test flag is clear. While it is set, and with stop clear and osc_tick high every cycle, freq_test is a square wave of period 2^(FT_BIT+1) cycles at 50% duty.
- R12: Time bytes are stored as written, with only unused high bits dropped, and without any range correction. The calibration field keeps the value written and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | Timebase enable, nominally 32,768 per second |
| cs_a_n | input | 1 | Active-low select |
| cs_b | input | 1 | Active-high select |
| out_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W (11) | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not driven |
| rdata_oe | output | 1 | High when rdata is driven onto the bus |
| freq_test | output | 1 | Frequency-test square wave |

## Verification
The assertions check on every cycle that the output-drive flag follows the previous cycle's strobes. They also check that the live time cannot move while hold stays set, that the snapshot copy cannot move while its flag stays set, that stop suppresses the one-second pulse, and that the test pin is quiet while its flag is clear. Only the bench scenarios can show what the values are: the BCD carries, month lengths with leap February, year wrap, exact tick counts per second, staged loading, and storage of out-of-range bytes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hrs;
    logic [7:0] mins;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t TIME_RESET = '{yr: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
                                       hrs: 8'h00, mins: 8'h00, sec: 8'h00};

  // Returns {wrapped, next value}; values at or beyond lim wrap to base.
  function automatic logic [8:0] bcd_next(input logic [7:0] v, input logic [7:0] lim,
                                          input logic [7:0] base);
    if (v >= lim)
      return {1'b1, base};
    else if (v[3:0] >= 4'd9)
      return {1'b0, v[7:4] + 4'd1, 4'd0};
    else
      return {1'b0, v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] ybin;
    ybin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
    case (mon)
      8'h02: return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int FT_BIT        = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic stop,
  input  logic ft_en,
  output logic sec_pulse,
  output logic ft_wave
);

  localparam int CNT_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      sec_pulse <= 1'b0;
      ft_wave   <= 1'b0;
    end else begin
      sec_pulse <= 1'b0;
      ft_wave   <= ft_en & cnt[FT_BIT];
      if (stop) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == LAST) begin
          cnt       <= '0;
          sec_pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sec_pulse,
  input  logic       hold,
  input  logic       stage_load,
  input  logic       stage_commit,
  input  logic       st_we,
  input  logic [2:0] st_idx,
  input  logic [7:0] st_data,
  output rtc_time_t  time_o
);

  rtc_time_t live, stage;
  logic [8:0] n_sec, n_min, n_hrs, n_dow, n_date, n_mon, n_yr;

  always_comb begin
    n_sec  = bcd_next(live.sec,  8'h59, 8'h00);
    n_min  = bcd_next(live.mins, 8'h59, 8'h00);
    n_hrs  = bcd_next(live.hrs,  8'h23, 8'h00);
    n_dow  = bcd_next(live.dow,  8'h07, 8'h01);
    n_date = bcd_next(live.date, last_day(live.mon, live.yr), 8'h01);
    n_mon  = bcd_next(live.mon,  8'h12, 8'h01);
    n_yr   = bcd_next(live.yr,   8'h99, 8'h00);
  end

  // staging copy written by the host while hold is set
  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= TIME_RESET;
    end else if (stage_load) begin
      stage <= live;
    end else if (st_we) begin
      case (st_idx)
        3'd1: stage.sec  <= {1'b0, st_data[6:0]};
        3'd2: stage.mins <= {1'b0, st_data[6:0]};
        3'd3: stage.hrs  <= {2'b0, st_data[5:0]};
        3'd4: stage.dow  <= {5'b0, st_data[2:0]};
        3'd5: stage.date <= {2'b0, st_data[5:0]};
        3'd6: stage.mon  <= {3'b0, st_data[4:0]};
        3'd7: stage.yr   <= st_data;
        default: ;
      endcase
    end
  end

  // live counters with carry cascade
  always_ff @(posedge clk) begin
    if (rst) begin
      live <= TIME_RESET;
    end else if (stage_commit) begin
      live <= stage;
    end else if (sec_pulse && !hold) begin
      live.sec <= n_sec[7:0];
      if (n_sec[8]) begin
        live.mins <= n_min[7:0];
        if (n_min[8]) begin
          live.hrs <= n_hrs[7:0];
          if (n_hrs[8]) begin
            live.dow  <= n_dow[7:0];
            live.date <= n_date[7:0];
            if (n_date[8]) begin
              live.mon <= n_mon[7:0];
              if (n_mon[8]) live.yr <= n_yr[7:0];
            end
          end
        end
      end
    end
  end

  assign time_o = live;

endmodule

// File: rtl/rtc_ram.sv
module rtc_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/rtc_sram_top.sv
module rtc_sram_top
  import rtc_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int TICKS_PER_SEC = 32768,
  parameter int FT_BIT        = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic              cs_a_n,
  input  logic              cs_b,
  input  logic              out_en_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rdata_oe,
  output logic              freq_test
);

  localparam int WIN_W = ADDR_W - 3;

  logic       sel, wr_cyc, rd_cyc, in_win, wr_ctrl, wr_time, ram_we;
  logic [2:0] idx;
  logic       hold_q, snap_q, stop_q, ftst_q;
  logic [4:0] cal_q;
  logic       hold_set, hold_clr, snap_set;
  logic       sec_pulse;
  rtc_time_t  live_time, snap_time, view;
  logic [7:0] ram_q, clk_byte, clk_q;
  logic       sel_clk_q;

  assign sel     = !cs_a_n && cs_b;
  assign wr_cyc  = sel && !wr_en_n;
  assign rd_cyc  = sel && wr_en_n && !out_en_n;
  assign in_win  = (addr[ADDR_W-1:3] == {WIN_W{1'b1}});
  assign idx     = addr[2:0];
  assign ram_we  = wr_cyc && !in_win;
  assign wr_ctrl = wr_cyc && in_win && (idx == 3'd0);
  assign wr_time = wr_cyc && in_win && (idx != 3'd0) && hold_q;

  assign hold_set = wr_ctrl &&  wdata[7] && !hold_q;
  assign hold_clr = wr_ctrl && !wdata[7] &&  hold_q;
  assign snap_set = wr_ctrl &&  wdata[6] && !snap_q;

  // control flags and calibration field
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      snap_q <= 1'b0;
      stop_q <= 1'b0;
      ftst_q <= 1'b0;
      cal_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        hold_q <= wdata[7];
        snap_q <= wdata[6];
        stop_q <= wdata[5];
        ftst_q <= wdata[4];
      end
      if (wr_cyc && in_win && (idx == 3'd4)) cal_q <= wdata[7:3];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) snap_time <= TIME_RESET;
    else if (snap_set) snap_time <= live_time;
  end

  rtc_divider #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .FT_BIT       (FT_BIT)
  ) u_div (
    .clk      (clk),
    .rst      (rst),
    .tick     (osc_tick),
    .stop     (stop_q),
    .ft_en    (ftst_q),
    .sec_pulse(sec_pulse),
    .ft_wave  (freq_test)
  );

  rtc_calendar u_cal (
    .clk         (clk),
    .rst         (rst),
    .sec_pulse   (sec_pulse),
    .hold        (hold_q),
    .stage_load  (hold_set),
    .stage_commit(hold_clr),
    .st_we       (wr_time),
    .st_idx      (idx),
    .st_data     (wdata),
    .time_o      (live_time)
  );

  rtc_ram #(
    .ADDR_W(ADDR_W),
    .DATA_W(BYTE_W)
  ) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .addr (addr),
    .wdata(wdata),
    .rdata(ram_q)
  );

  assign view = snap_q ? snap_time : live_time;

  always_comb begin
    case (idx)
      3'd0: clk_byte = {hold_q, snap_q, stop_q, ftst_q, 4'b0000};
      3'd1: clk_byte = view.sec;
      3'd2: clk_byte = view.mins;
      3'd3: clk_byte = view.hrs;
      3'd4: clk_byte = {cal_q, view.dow[2:0]};
      3'd5: clk_byte = view.date;
      3'd6: clk_byte = view.mon;
      default: clk_byte = view.yr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_oe  <= 1'b0;
      sel_clk_q <= 1'b0;
      clk_q     <= '0;
    end else begin
      rdata_oe <= rd_cyc;
      if (rd_cyc) begin
        sel_clk_q <= in_win;
        clk_q     <= clk_byte;
      end
    end
  end

  assign rdata = rdata_oe ? (sel_clk_q ? clk_q : ram_q) : 8'h00;

endmodule

// File: rtl/rtc_sram_checker.sv
module rtc_sram_checker
  import rtc_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      cs_a_n,
  input logic      cs_b,
  input logic      out_en_n,
  input logic      wr_en_n,
  input logic      rdata_oe,
  input logic      hold_q,
  input logic      snap_q,
  input logic      stop_q,
  input logic      ftst_q,
  input logic      sec_pulse,
  input logic      freq_test,
  input rtc_time_t live_time,
  input rtc_time_t snap_time
);

  logic rd_req;
  assign rd_req = !cs_a_n && cs_b && wr_en_n && !out_en_n;

  assert_read_drive_R3: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rdata_oe);

  assert_bus_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rdata_oe);

  assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> (!hold_q || $stable(live_time)));

  assert_snap_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    snap_q |=> (!snap_q || $stable(snap_time)));

  assert_stop_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    stop_q |=> !sec_pulse);

  assert_ft_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !ftst_q |=> !freq_test);

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |=> !sec_pulse);

endmodule

bind rtc_sram_top rtc_sram_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_a_n   (cs_a_n),
  .cs_b     (cs_b),
  .out_en_n (out_en_n),
  .wr_en_n  (wr_en_n),
  .rdata_oe (rdata_oe),
  .hold_q   (hold_q),
  .snap_q   (snap_q),
  .stop_q   (stop_q),
  .ftst_q   (ftst_q),
  .sec_pulse(sec_pulse),
  .freq_test(freq_test),
  .live_time(live_time),
  .snap_time(snap_time)
);

// File: tb/rtc_sram_top_test.sv
module rtc_sram_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 11;
  localparam int DIV = 16;
  localparam int FTB = 1;
  localparam logic [AW-1:0] BASE = AW'((1 << AW) - 8);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          osc_tick = 1'b0;
  logic          cs_a_n = 1'b1, cs_b = 1'b0, out_en_n = 1'b1, wr_en_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          rdata_oe, freq_test;

  int checks = 0;
  int fails  = 0;

  rtc_sram_top #(.ADDR_W(AW), .TICKS_PER_SEC(DIV), .FT_BIT(FTB)) uut (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .out_en_n(out_en_n), .wr_en_n(wr_en_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe), .freq_test(freq_test)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    cs_a_n = 1'b1; cs_b = 1'b0; wr_en_n = 1'b1; out_en_n = 1'b1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; cs_a_n = 1'b0; cs_b = 1'b1; wr_en_n = 1'b0; out_en_n = 1'b0;
    @(negedge clk);
    idle_bus();
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic en);
    @(negedge clk);
    addr = a; cs_a_n = 1'b0; cs_b = 1'b1; wr_en_n = 1'b1; out_en_n = 1'b0;
    @(negedge clk);
    d = rdata; en = rdata_oe;
    idle_bus();
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    logic en;
    rd(a, d, en);
    check({req, " drive"}, {7'd0, en}, 8'h01);
    check(req, d, exp);
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    osc_tick = 1'b1;
    repeat (n) @(negedge clk);
    osc_tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // leaves stop set so nothing moves until the caller releases it
  task automatic set_time(input logic [7:0] s, m, h, dw, dt, mo, y);
    wr(BASE, 8'hA0);
    wr(BASE + 1, s); wr(BASE + 2, m); wr(BASE + 3, h); wr(BASE + 4, dw);
    wr(BASE + 5, dt); wr(BASE + 6, mo); wr(BASE + 7, y);
    wr(BASE, 8'h20);
  endtask

  task automatic one_second();
    wr(BASE, 8'h00);
    run_ticks(DIV);
    wr(BASE, 8'h20);
  endtask

  task automatic test_reset();
    check("R1 idle oe", {7'd0, rdata_oe}, 8'h00);
    rd_chk("R1 ctrl", BASE, 8'h00);
    rd_chk("R1 sec", BASE + 1, 8'h00);
    rd_chk("R1 min", BASE + 2, 8'h00);
    rd_chk("R1 hour", BASE + 3, 8'h00);
    rd_chk("R1 day", BASE + 4, 8'h01);
    rd_chk("R1 date", BASE + 5, 8'h01);
    rd_chk("R1 month", BASE + 6, 8'h01);
    rd_chk("R1 year", BASE + 7, 8'h00);
  endtask

  task automatic test_ram();
    logic [7:0] d;
    logic en;
    wr('0, 8'hA5);
    wr(BASE - 1, 8'h3C);
    rd_chk("R2 low", '0, 8'hA5);
    rd_chk("R2 top", BASE - 1, 8'h3C);
    @(negedge clk);
    addr = AW'(5); wdata = 8'h77; cs_a_n = 1'b1; cs_b = 1'b1; wr_en_n = 1'b0;
    @(negedge clk);
    idle_bus();
    wr(AW'(5), 8'h11);
    @(negedge clk);
    addr = AW'(5); wdata = 8'h99; cs_a_n = 1'b0; cs_b = 1'b0; wr_en_n = 1'b0;
    @(negedge clk);
    idle_bus();
    rd_chk("R2 deselected write", AW'(5), 8'h11);
    @(negedge clk);
    addr = '0; cs_a_n = 1'b0; cs_b = 1'b1; wr_en_n = 1'b1; out_en_n = 1'b1;
    @(negedge clk);
    check("R3 oe high", {7'd0, rdata_oe}, 8'h00);
    cs_b = 1'b0; out_en_n = 1'b0;
    @(negedge clk);
    check("R3 cs_b low", {7'd0, rdata_oe}, 8'h00);
    idle_bus();
    rd(AW'(0), d, en);
    check("R3 read", d, 8'hA5);
  endtask

  task automatic test_second();
    set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(BASE, 8'h00);
    run_ticks(DIV - 1);
    wr(BASE, 8'h20);
    rd_chk("R5 short", BASE + 1, 8'h00);
    set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    one_second();
    rd_chk("R5 full", BASE + 1, 8'h01);
    set_time(8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    one_second();
    rd_chk("R6 digit carry", BASE + 1, 8'h10);
  endtask

  task automatic test_rollover();
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h03, 8'h24);
    one_second();
    rd_chk("R6 sec", BASE + 1, 8'h00);
    rd_chk("R6 min", BASE + 2, 8'h00);
    rd_chk("R6 hour", BASE + 3, 8'h00);
    rd_chk("R6 day wrap", BASE + 4, 8'h01);
    rd_chk("R6 date", BASE + 5, 8'h16);
    set_time(8'h59, 8'h29, 8'h13, 8'h03, 8'h15, 8'h03, 8'h24);
    one_second();
    rd_chk("R6 min carry", BASE + 2, 8'h30);
    rd_chk("R6 hour kept", BASE + 3, 8'h13);
  endtask

  task automatic test_month_end();
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    one_second();
    rd_chk("R7 leap date", BASE + 5, 8'h29);
    rd_chk("R7 leap month", BASE + 6, 8'h02);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    one_second();
    rd_chk("R7 plain date", BASE + 5, 8'h01);
    rd_chk("R7 plain month", BASE + 6, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h10);
    one_second();
    rd_chk("R7 april", BASE + 6, 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h12, 8'h99);
    one_second();
    rd_chk("R7 new year date", BASE + 5, 8'h01);
    rd_chk("R7 new year month", BASE + 6, 8'h01);
    rd_chk("R7 year wrap", BASE + 7, 8'h00);
  endtask

  task automatic test_hold();
    set_time(8'h05, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(BASE, 8'h80);
    wr(BASE + 1, 8'h42);
    run_ticks(DIV * 2);
    rd_chk("R8 frozen", BASE + 1, 8'h05);
    wr(BASE, 8'h20);
    rd_chk("R8 loaded", BASE + 1, 8'h42);
    rd_chk("R8 unwritten kept", BASE + 2, 8'h00);
    wr(BASE + 1, 8'h33);
    rd_chk("R8 direct ignored", BASE + 1, 8'h42);
  endtask

  task automatic test_snapshot();
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(BASE, 8'h60);
    wr(BASE, 8'h40);
    run_ticks(DIV);
    rd_chk("R9 frozen read", BASE + 1, 8'h10);
    wr(BASE, 8'h20);
    rd_chk("R9 live after", BASE + 1, 8'h11);
  endtask

  task automatic test_stop();
    set_time(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    run_ticks(DIV * 3);
    rd_chk("R10 stopped", BASE + 1, 8'h20);
    wr(BASE, 8'h00);
    run_ticks(DIV - 1);
    wr(BASE, 8'h20);
    rd_chk("R10 restart short", BASE + 1, 8'h20);
    one_second();
    rd_chk("R10 restart full", BASE + 1, 8'h21);
  endtask

  task automatic test_freq();
    int highs;
    wr(BASE, 8'h10);
    @(negedge clk);
    osc_tick = 1'b1;
    repeat (4) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 4 * (1 << FTB); i++) begin
      if (freq_test) highs++;
      @(negedge clk);
    end
    check("R11 square duty", 8'(highs), 8'(2 * (1 << FTB)));
    osc_tick = 1'b0;
    wr(BASE, 8'h00);
    @(negedge clk);
    osc_tick = 1'b1;
    repeat (2) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 4 * (1 << FTB); i++) begin
      if (freq_test) highs++;
      @(negedge clk);
    end
    osc_tick = 1'b0;
    check("R11 quiet", 8'(highs), 8'h00);
  endtask

  task automatic test_raw_store();
    set_time(8'h7A, 8'h00, 8'h00, 8'h03, 8'h01, 8'h01, 8'h00);
    rd_chk("R12 raw sec", BASE + 1, 8'h7A);
    wr(BASE + 4, 8'hF9);
    rd_chk("R12 calibration", BASE + 4, 8'hFB);
    rd_chk("R4 ctrl bits", BASE, 8'h20);
  endtask

  initial begin
    idle_bus();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_ram();
    test_second();
    test_rollover();
    test_month_end();
    test_hold();
    test_snapshot();
    test_stop();
    test_freq();
    test_raw_store();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule